// File: doc/BRIEF.md
# Power-Management Command Port with SMI Gating

This block decodes single-byte commands that the host writes to a power-management command port. Two reserved codes switch the platform in and out of ACPI mode. 0xF1 sets the SCI-enable level and 0xF0 clears it. Neither of them raises a system-management interrupt (SMI). Every other code is a request for SMM service. Such a code produces a one-cycle SMI pulse, but only when the SMI-enable bit of a small configuration window is set.

The configuration window is four bytes wide. Byte lane 0 maps to configuration offset 0x58, and lane 3 maps to offset 0x5B. Writes to the window carry a byte-enable mask, so one-, two- and four-byte accesses are all handled.

The defaults at reset depend on a strap that tells whether SMM is supported:
- With SMM supported, the whole window resets to zero.
- Without SMM, lane 3 resets to 0x02. This marks SMM as already initialised.

A scratch status byte sits next to the command port. It can be written and read back, and it has no side effects.

Top module: `pm_cmd_smi`

## Requirements
- R1: A command write of 0xF1 drives `sci_en` to 1 from the clock edge that takes the write, and `smi_pulse` stays 0 in the following cycle.
- R2: A command write of 0xF0 drives `sci_en` to 0 from the clock edge that takes the write, and `smi_pulse` stays 0 in the following cycle.
- R3: Any command code other than 0xF0 and 0xF1 raises `smi_pulse` for exactly one cycle when bit 1 of window lane 3 (offset 0x5B, `cfg_rdata[25]`) is 1. The pulse is high in the cycle after the edge that takes the write and low again one cycle later.
- R4: Any command code other than 0xF0 and 0xF1 written while bit 1 of lane 3 is 0 leaves `smi_pulse` at 0. Such a code never changes `sci_en`.
- R5: During reset with `smm_supported` high, `cfg_rdata` is 0x00000000. `sci_en`, `smi_pulse` and `stat_rdata` are also 0.
- R6: During reset with `smm_supported` low, `cfg_rdata` is 0x02000000 (lane 3 = 0x02). This enables SMI as soon as reset is released.
- R7: A window write updates only the byte lanes whose `cfg_be` bit is 1. Lane i is `cfg_wdata[8i+7:8i]`.
- R8: A status write stores `stat_wdata`, which is read back on `stat_rdata` from the next cycle. It affects neither `sci_en` nor `smi_pulse`.
- R9: When a command write and a window write fall in the same cycle, the SMI decision uses the SMI-enable bit as it was before that window write.
- R10: `smi_pulse` is never high in a cycle that does not follow a command write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smm_supported | input | 1 | Strap: 1 when SMM is supported; sampled during reset |
| cmd_we | input | 1 | Command port write strobe |
| cmd_wdata | input | 8 | Command byte |
| stat_we | input | 1 | Status scratch write strobe |
| stat_wdata | input | 8 | Status scratch write data |
| stat_rdata | output | 8 | Status scratch contents |
| cfg_we | input | 1 | Configuration window write strobe |
| cfg_be | input | 4 | Byte enables, lane 0 = offset 0x58 |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration window contents |
| smi_pulse | output | 1 | One-cycle SMI request |
| sci_en | output | 1 | SCI-enable level (ACPI mode) |

## Verification
The command decode is tried with the two reserved codes and with their neighbours 0xF2 and 0xEF, and also with 0x00 and 0xFF. Each of these other codes is written with the SMI-enable bit both set and clear. An exact-match decode separates the reserved pair from these codes, whereas a decode on a range or on a few bits would lump some of them together. The enable bit is driven through several byte-enable masks, and through a window write that lands in the same cycle as a command. These show whether only the addressed lanes change and whether the old enable value is used. Both strap levels are tried across reset.

// File: rtl/pm_cmd_smi.sv
module pm_cmd_smi #(
  parameter int CMD_W = 8,
  parameter logic [CMD_W-1:0] ACPI_ON_CODE  = 8'hF1,
  parameter logic [CMD_W-1:0] ACPI_OFF_CODE = 8'hF0,
  parameter int WIN_BYTES   = 4,
  parameter int SMI_EN_LANE = 3,
  parameter int SMI_EN_BIT  = 1,
  parameter logic [7:0] NO_SMM_LANE_VAL = 8'h02
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   smm_supported,
  input  logic                   cmd_we,
  input  logic [CMD_W-1:0]       cmd_wdata,
  input  logic                   stat_we,
  input  logic [7:0]             stat_wdata,
  output logic [7:0]             stat_rdata,
  input  logic                   cfg_we,
  input  logic [WIN_BYTES-1:0]   cfg_be,
  input  logic [WIN_BYTES*8-1:0] cfg_wdata,
  output logic [WIN_BYTES*8-1:0] cfg_rdata,
  output logic                   smi_pulse,
  output logic                   sci_en
);
  localparam int WIN_W = WIN_BYTES * 8;

  logic [WIN_W-1:0] win_q;
  logic             is_on, is_off, smi_en_now;

  assign is_on      = cmd_wdata == ACPI_ON_CODE;
  assign is_off     = cmd_wdata == ACPI_OFF_CODE;
  assign smi_en_now = win_q[SMI_EN_LANE*8 + SMI_EN_BIT];
  assign cfg_rdata  = win_q;

  always_ff @(posedge clk) begin
    for (int i = 0; i < WIN_BYTES; i++) begin
      if (!rst_n)
        win_q[i*8 +: 8] <= (i == SMI_EN_LANE && !smm_supported) ? NO_SMM_LANE_VAL : 8'h00;
      else if (cfg_we && cfg_be[i])
        win_q[i*8 +: 8] <= cfg_wdata[i*8 +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sci_en     <= 1'b0;
      smi_pulse  <= 1'b0;
      stat_rdata <= 8'h00;
    end else begin
      if (cmd_we && is_on)  sci_en <= 1'b1;
      if (cmd_we && is_off) sci_en <= 1'b0;
      smi_pulse <= cmd_we && !is_on && !is_off && smi_en_now;
      if (stat_we) stat_rdata <= stat_wdata;
    end
  end

  // R1
  acpi_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_we && cmd_wdata == ACPI_ON_CODE |=> sci_en && !smi_pulse);

  // R2
  acpi_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_we && cmd_wdata == ACPI_OFF_CODE |=> !sci_en && !smi_pulse);

  // R3 R9
  smi_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_we && cmd_wdata != ACPI_ON_CODE && cmd_wdata != ACPI_OFF_CODE
      && cfg_rdata[SMI_EN_LANE*8 + SMI_EN_BIT] |=> smi_pulse);

  // R4
  smi_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_we && !cfg_rdata[SMI_EN_LANE*8 + SMI_EN_BIT] |=> !smi_pulse);

  // R4
  sci_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_we && (cmd_wdata == ACPI_ON_CODE || cmd_wdata == ACPI_OFF_CODE))
      |=> $stable(sci_en));

  // R10
  smi_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_we |=> !smi_pulse);

  // R8
  stat_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_we |=> stat_rdata == $past(stat_wdata));
endmodule

// File: tb/pm_cmd_smi_tb_top.sv
module pm_cmd_smi_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        smm_supported = 1'b1;
  logic        cmd_we = 1'b0;
  logic [7:0]  cmd_wdata = 8'h00;
  logic        stat_we = 1'b0;
  logic [7:0]  stat_wdata = 8'h00;
  logic [7:0]  stat_rdata;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_be = 4'h0;
  logic [31:0] cfg_wdata = 32'h0;
  logic [31:0] cfg_rdata;
  logic        smi_pulse, sci_en;

  int n_run = 0;
  int n_fail = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  pm_cmd_smi dut_i (
    .clk(clk), .rst_n(rst_n), .smm_supported(smm_supported),
    .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
    .stat_we(stat_we), .stat_wdata(stat_wdata), .stat_rdata(stat_rdata),
    .cfg_we(cfg_we), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .smi_pulse(smi_pulse), .sci_en(sci_en)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 5000) begin
      n_fail++;
      $display("FAIL watchdog: actual cycle %0d expected < 5000", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(logic strap);
    @(negedge clk);
    rst_n = 1'b0;
    smm_supported = strap;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic release_reset();
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // Drives one command; returns smi seen the cycle after and the cycle after that.
  task automatic send_cmd(logic [7:0] code, output logic smi1, output logic smi2);
    cmd_we = 1'b1; cmd_wdata = code;
    @(negedge clk);
    cmd_we = 1'b0;
    smi1 = smi_pulse;
    @(negedge clk);
    smi2 = smi_pulse;
  endtask

  task automatic cfg_write(logic [3:0] be, logic [31:0] d);
    cfg_we = 1'b1; cfg_be = be; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0; cfg_be = 4'h0;
  endtask

  task automatic t_reset_strap_hi();
    do_reset(1'b1);
    check("R5 window", cfg_rdata, 32'h0);
    check("R5 sci_en", {31'b0, sci_en}, 0);
    check("R5 smi", {31'b0, smi_pulse}, 0);
    check("R5 status", {24'b0, stat_rdata}, 0);
    release_reset();
  endtask

  task automatic t_gated_off();
    logic a, b;
    foreach (gated_codes[k]) begin
      send_cmd(gated_codes[k], a, b);
      check("R4 no smi when disabled", {31'b0, a}, 0);
      check("R4 sci unchanged", {31'b0, sci_en}, 0);
    end
  endtask

  task automatic t_acpi_on_off();
    logic a, b;
    send_cmd(8'hF1, a, b);
    check("R1 sci_en set", {31'b0, sci_en}, 1);
    check("R1 no smi", {31'b0, a}, 0);
    send_cmd(8'hF1, a, b);
    check("R1 sci_en stays set", {31'b0, sci_en}, 1);
    send_cmd(8'hF0, a, b);
    check("R2 sci_en clear", {31'b0, sci_en}, 0);
    check("R2 no smi", {31'b0, a}, 0);
  endtask

  task automatic t_byte_enables();
    cfg_write(4'b0101, 32'hAABBCCDD);
    check("R7 lanes 0 and 2", cfg_rdata, 32'h00BB00DD);
    cfg_write(4'b1000, 32'h02FFFFFF);
    check("R7 lane 3 only", cfg_rdata, 32'h02BB00DD);
    cfg_write(4'b0010, 32'h00001100);
    check("R7 lane 1 only", cfg_rdata, 32'h02BB11DD);
  endtask

  task automatic t_smi_enabled();
    logic a, b;
    send_cmd(8'hF1, a, b);
    check("R1 sci set with smi enabled", {31'b0, sci_en}, 1);
    check("R1 no smi with smi enabled", {31'b0, a}, 0);
    foreach (gated_codes[k]) begin
      send_cmd(gated_codes[k], a, b);
      check("R3 smi raised", {31'b0, a}, 1);
      check("R3 smi one cycle", {31'b0, b}, 0);
      check("R4 sci unchanged by other code", {31'b0, sci_en}, 1);
    end
    send_cmd(8'hF0, a, b);
    check("R2 no smi with smi enabled", {31'b0, a}, 0);
    check("R10 idle no smi", {31'b0, b}, 0);
  endtask

  task automatic t_status();
    stat_we = 1'b1; stat_wdata = 8'h5A;
    @(negedge clk);
    stat_we = 1'b0;
    check("R8 status readback", {24'b0, stat_rdata}, 32'h5A);
    check("R8 no smi", {31'b0, smi_pulse}, 0);
    check("R8 sci unchanged", {31'b0, sci_en}, 0);
  endtask

  task automatic t_same_cycle();
    logic a, b;
    cmd_we = 1'b1; cmd_wdata = 8'h55;
    cfg_we = 1'b1; cfg_be = 4'b1000; cfg_wdata = 32'h0;
    @(negedge clk);
    cmd_we = 1'b0; cfg_we = 1'b0; cfg_be = 4'h0;
    check("R9 old enable used", {31'b0, smi_pulse}, 1);
    send_cmd(8'h55, a, b);
    check("R9 new enable later", {31'b0, a}, 0);
    cmd_we = 1'b1; cmd_wdata = 8'h66;
    cfg_we = 1'b1; cfg_be = 4'b1000; cfg_wdata = 32'h02000000;
    @(negedge clk);
    cmd_we = 1'b0; cfg_we = 1'b0; cfg_be = 4'h0;
    check("R9 old disable used", {31'b0, smi_pulse}, 0);
  endtask

  task automatic t_strap_lo();
    logic a, b;
    do_reset(1'b0);
    check("R6 window no smm", cfg_rdata, 32'h02000000);
    check("R5 sci_en in reset", {31'b0, sci_en}, 0);
    release_reset();
    send_cmd(8'h20, a, b);
    check("R6 smi enabled by strap", {31'b0, a}, 1);
  endtask

  logic [7:0] gated_codes [4] = '{8'hF2, 8'hEF, 8'h00, 8'hFF};

  initial begin
    t_reset_strap_hi();
    t_gated_off();
    t_acpi_on_off();
    t_status();
    t_byte_enables();
    t_smi_enabled();
    t_same_cycle();
    t_strap_lo();
    t_reset_strap_hi();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule